// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Selective Status Update

This block is the purely combinational arithmetic/logic stage of a small 8-bit RISC core. Each cycle the core gives it an operation code, two operands and the current six-bit status vector. The block returns the operation result, a new status vector and a write strobe that says whether the result should go back to the register file. Every operation rewrites only the status bits it owns. All other bits pass through from the incoming vector unchanged, so the core can always latch the whole returned vector.

The carry used by add-with-carry, subtract-with-carry, compare-with-carry and the rotates is the C bit of the incoming status vector. Single-operand operations read only `opa_i`. Compares produce the difference on `res_o` but drop the write strobe.

Top module: `alu8_core`

## Requirements
- R1: Opcodes on `op_i`: 0 add, 1 add-with-carry, 2 sub, 3 sub-with-carry, 4 compare, 5 compare-with-carry, 6 and, 7 or, 8 xor, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 shift-left, 14 shift-right, 15 rotate-left, 16 rotate-right, 17 arithmetic-shift-right, 18 nibble-swap. Status bits are bit5 H, bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C. Add and add-with-carry return a+b(+C) and set H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N and Z.
- R2: Sub and sub-with-carry return a-b(-C) and set H and C as borrows, V, N and Z. For sub-with-carry, Z is 0 when the difference is nonzero and otherwise keeps its incoming value.
- R3: Compare and compare-with-carry set the flags exactly as sub and sub-with-carry do, put the difference on `res_o`, and drive `wr_o` low.
- R4: And, or and xor return the bitwise result, set Z and N, force V to 0, and keep H and C.
- R5: One's complement returns 0xFF-a, forces C=1 and V=0, sets N and Z, and keeps H. `opb_i` has no effect.
- R6: Negate returns 0x00-a and sets H, C (1 unless a is 0), V (1 only for 0x80), N and Z.
- R7: Increment and decrement return a+1 and a-1. They set Z and N, and set V only for results 0x80 and 0x7F respectively. They keep C and H.
- R8: Shift-left fills bit 0 with 0 and moves bit 7 into C. Shift-right fills bit 7 with 0 and moves bit 0 into C. Both set Z and N and keep H.
- R9: Rotate-left and rotate-right move the incoming C into the vacated bit and the outgoing bit into C. Arithmetic-shift-right keeps bit 7 and moves bit 0 into C. For all shifts and rotates V = N xor new C, and H is kept.
- R10: Nibble-swap exchanges bits 7:4 with 3:0 and returns the status vector unchanged.
- R11: Whenever an operation writes N or V, S equals the new N xor the new V.
- R12: Opcodes 19 to 31 return `opa_i`, leave the status vector unchanged and drive `wr_o` low. All opcodes 0 to 18 except the compares drive `wr_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (encoding in R1) |
| opa_i | input | 8 | First operand, also the sole operand of single-operand operations |
| opb_i | input | 8 | Second operand |
| flags_i | input | 6 | Current status {H,S,V,N,Z,C} |
| res_o | output | 8 | Operation result |
| flags_o | output | 6 | Updated status {H,S,V,N,Z,C} |
| wr_o | output | 1 | Result write strobe |

## Verification
The bench builds the block at its default width of 8 bits, with the half-carry taken at the 4-bit nibble boundary. That is the only configuration where the sign-boundary values 0x7F, 0x80 and 0xFF and the nibble carry at bit 3 land on the byte values the requirements name. The directed cases aim at these boundaries: signed overflow on add, increment and negate, a borrow out of bit 3, a chained zero across a multi-byte compare, and rotates that shift the incoming carry into the result. Unused opcodes and the pass-through of flags owned by other operations are checked at the ports.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_SHL  = 5'd13,
        OP_SHR  = 5'd14,
        OP_ROL  = 5'd15,
        OP_ROR  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8,
    parameter int HALF  = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             half_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full_w;
    logic [HALF:0]  low_w;

    always_comb begin
        if (sub_i) begin
            full_w = {1'b0, x_i} - {1'b0, y_i} - {{WIDTH{1'b0}}, cin_i};
            low_w  = {1'b0, x_i[HALF-1:0]} - {1'b0, y_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
        end else begin
            full_w = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
            low_w  = {1'b0, x_i[HALF-1:0]} + {1'b0, y_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
        end
        sum_o   = full_w[WIDTH-1:0];
        carry_o = full_w[WIDTH];
        half_o  = low_w[HALF];
        if (sub_i)
            ovf_o = (x_i[MSB] != y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
        else
            ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int MSB  = WIDTH - 1;
    localparam int HALF = WIDTH / 2;

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM:  begin res_o = ~a_i; cout_o = 1'b1; end
            OP_SHL:  begin res_o = {a_i[MSB-1:0], 1'b0};  cout_o = a_i[MSB]; end
            OP_SHR:  begin res_o = {1'b0, a_i[MSB:1]};    cout_o = a_i[0]; end
            OP_ROL:  begin res_o = {a_i[MSB-1:0], cin_i}; cout_o = a_i[MSB]; end
            OP_ROR:  begin res_o = {cin_i, a_i[MSB:1]};   cout_o = a_i[0]; end
            OP_ASR:  begin res_o = {a_i[MSB], a_i[MSB:1]}; cout_o = a_i[0]; end
            OP_SWAP: res_o = {a_i[HALF-1:0], a_i[MSB:HALF]};
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int HALF  = 4
) (
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [5:0]       flags_i,
    output logic [WIDTH-1:0] res_o,
    output logic [5:0]       flags_o,
    output logic             wr_o
);
    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SMAX    = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] SMIN    = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic [WIDTH-1:0] res;
        alu_flags_t       flg;
        logic             wr;
    } alu_out_t;

    alu_op_e    op_w;
    alu_flags_t fin_w;
    alu_out_t   out_d;

    logic [WIDTH-1:0] as_x, as_y, as_sum, bo_res;
    logic             as_cin, as_sub, as_c, as_h, as_v, bo_c;

    assign op_w  = alu_op_e'(op_i);
    assign fin_w = alu_flags_t'(flags_i);

    always_comb begin
        as_x   = opa_i;
        as_y   = opb_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op_w)
            OP_ADC:              as_cin = fin_w.c;
            OP_SUB, OP_CP:       as_sub = 1'b1;
            OP_SBC, OP_CPC:      begin as_sub = 1'b1; as_cin = fin_w.c; end
            OP_NEG:              begin as_sub = 1'b1; as_x = '0; as_y = opa_i; end
            OP_INC:              as_y = ONE;
            OP_DEC:              begin as_sub = 1'b1; as_y = ONE; end
            default: ;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH), .HALF(HALF)) u_addsub (
        .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .carry_o(as_c), .half_o(as_h), .ovf_o(as_v)
    );

    alu8_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op_i(op_w), .a_i(opa_i), .b_i(opb_i), .cin_i(fin_w.c),
        .res_o(bo_res), .cout_o(bo_c)
    );

    always_comb begin
        out_d     = '0;
        out_d.res = opa_i;
        out_d.flg = fin_w;
        out_d.wr  = 1'b1;
        case (op_w)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                out_d.res   = as_sum;
                out_d.flg.h = as_h;
                out_d.flg.c = as_c;
                out_d.flg.v = as_v;
                out_d.flg.n = as_sum[MSB];
                if (op_w == OP_SBC || op_w == OP_CPC)
                    out_d.flg.z = (as_sum == '0) && fin_w.z;
                else
                    out_d.flg.z = (as_sum == '0);
                out_d.wr = !(op_w == OP_CP || op_w == OP_CPC);
            end
            OP_INC, OP_DEC: begin
                out_d.res   = as_sum;
                out_d.flg.n = as_sum[MSB];
                out_d.flg.z = (as_sum == '0);
                out_d.flg.v = (op_w == OP_INC) ? (as_sum == SMIN) : (as_sum == SMAX);
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                out_d.res   = bo_res;
                out_d.flg.n = bo_res[MSB];
                out_d.flg.z = (bo_res == '0);
                out_d.flg.v = 1'b0;
                out_d.flg.c = bo_c;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_ASR: begin
                out_d.res   = bo_res;
                out_d.flg.n = bo_res[MSB];
                out_d.flg.z = (bo_res == '0);
                out_d.flg.c = bo_c;
                out_d.flg.v = bo_res[MSB] ^ bo_c;
            end
            OP_SWAP: out_d.res = bo_res;
            default: out_d.wr = 1'b0;
        endcase
        if (op_w <= OP_ASR)
            out_d.flg.s = out_d.flg.n ^ out_d.flg.v;
    end

    assign res_o   = out_d.res;
    assign flags_o = out_d.flg;
    assign wr_o    = out_d.wr;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic [4:0]       op_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [5:0]       flags_i,
    input logic [WIDTH-1:0] res_o,
    input logic [5:0]       flags_o,
    input logic             wr_o
);
    always_comb begin
        if (!$isunknown({op_i, opa_i, opb_i, flags_i})) begin
            if (op_i == 5'd4 || op_i == 5'd5)
                AST_CMP_NO_WRITE: assert (!wr_o) else $error("compare wrote result"); // R3
            if ((op_i == 5'd3 || op_i == 5'd5) && !flags_i[1])
                AST_CHAIN_Z_HELD_LOW: assert (!flags_o[1]) else $error("chained Z set"); // R2
            if (op_i >= 5'd6 && op_i <= 5'd8)
                AST_LOGIC_V_CLEAR: assert (!flags_o[3] && flags_o[5] == flags_i[5] && flags_o[0] == flags_i[0]) else $error("logic flags"); // R4
            if (op_i == 5'd9)
                AST_COM_CARRY_SET: assert (flags_o[0] && !flags_o[3]) else $error("complement flags"); // R5
            if (op_i == 5'd11 || op_i == 5'd12)
                AST_STEP_KEEPS_CH: assert (flags_o[0] == flags_i[0] && flags_o[5] == flags_i[5]) else $error("inc/dec touched C/H"); // R7
            if (op_i >= 5'd13 && op_i <= 5'd17)
                AST_SHIFT_V_RULE: assert (flags_o[3] == (res_o[WIDTH-1] ^ flags_o[0])) else $error("shift V"); // R9
            if (op_i == 5'd18)
                AST_SWAP_FLAGS_KEEP: assert (flags_o == flags_i && wr_o) else $error("swap flags"); // R10
            if (op_i <= 5'd17)
                AST_SIGN_TEST: assert (flags_o[4] == (flags_o[2] ^ flags_o[3])) else $error("S mismatch"); // R11
            if (op_i > 5'd18)
                AST_UNUSED_INERT: assert (!wr_o && flags_o == flags_i && res_o == opa_i) else $error("unused op active"); // R12
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .wr_o(wr_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op;
    logic [7:0] a, b;
    logic [5:0] fl;
    logic [7:0] res;
    logic [5:0] flo;
    logic       wr;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;

    alu8_core uut (
        .op_i(op), .opa_i(a), .opb_i(b), .flags_i(fl),
        .res_o(res), .flags_o(flo), .wr_o(wr)
    );

    task automatic run(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [5:0] f, input logic [7:0] er, input logic [5:0] ef,
                       input logic ew, input string tag);
        @(negedge clk);
        op = o; a = x; b = y; fl = f;
        #1;
        n_chk++;
        if (res !== er || flo !== ef || wr !== ew) begin
            n_err++;
            $display("FAIL %s op=%0d a=%h: res=%h flags=%h wr=%b expected res=%h flags=%h wr=%b",
                     tag, o, x, res, flo, wr, er, ef, ew);
        end
    endtask

    task automatic t_reset_idle();
        run(5'd0, 8'h00, 8'h00, 6'h00, 8'h00, 6'h02, 1'b1, "R1 idle add");
    endtask

    task automatic t_add();
        run(5'd0, 8'h0F, 8'h01, 6'h00, 8'h10, 6'h20, 1'b1, "R1 half carry");
        run(5'd0, 8'h80, 8'h80, 6'h00, 8'h00, 6'h1B, 1'b1, "R1 R11 overflow");
        run(5'd1, 8'h7F, 8'h00, 6'h01, 8'h80, 6'h2C, 1'b1, "R1 adc carry in");
    endtask

    task automatic t_sub();
        run(5'd2, 8'h10, 8'h01, 6'h00, 8'h0F, 6'h20, 1'b1, "R2 half borrow");
        run(5'd2, 8'h00, 8'h01, 6'h00, 8'hFF, 6'h35, 1'b1, "R2 borrow");
        run(5'd3, 8'h05, 8'h04, 6'h01, 8'h00, 6'h00, 1'b1, "R2 sbc Z held low");
        run(5'd3, 8'h05, 8'h04, 6'h03, 8'h00, 6'h02, 1'b1, "R2 sbc Z kept");
    endtask

    task automatic t_cmp();
        run(5'd4, 8'h30, 8'h30, 6'h00, 8'h00, 6'h02, 1'b0, "R3 cp equal");
        run(5'd5, 8'h12, 8'h34, 6'h02, 8'hDE, 6'h35, 1'b0, "R3 cpc");
    endtask

    task automatic t_logic();
        run(5'd6, 8'hF0, 8'h0F, 6'h3F, 8'h00, 6'h23, 1'b1, "R4 and");
        run(5'd7, 8'h80, 8'h01, 6'h08, 8'h81, 6'h14, 1'b1, "R4 R11 or");
        run(5'd8, 8'hAA, 8'hAA, 6'h00, 8'h00, 6'h02, 1'b1, "R4 xor");
    endtask

    task automatic t_com_neg();
        run(5'd9,  8'h00, 8'h00, 6'h00, 8'hFF, 6'h15, 1'b1, "R5 com");
        run(5'd9,  8'h00, 8'hFF, 6'h00, 8'hFF, 6'h15, 1'b1, "R5 com b ignored");
        run(5'd10, 8'h80, 8'h00, 6'h00, 8'h80, 6'h0D, 1'b1, "R6 neg 0x80");
        run(5'd10, 8'h00, 8'h00, 6'h00, 8'h00, 6'h02, 1'b1, "R6 neg zero");
        run(5'd10, 8'h01, 8'h00, 6'h00, 8'hFF, 6'h35, 1'b1, "R6 neg one");
    endtask

    task automatic t_step();
        run(5'd11, 8'h7F, 8'h00, 6'h21, 8'h80, 6'h2D, 1'b1, "R7 inc overflow");
        run(5'd11, 8'hFF, 8'h00, 6'h00, 8'h00, 6'h02, 1'b1, "R7 inc wrap C kept");
        run(5'd12, 8'h80, 8'h00, 6'h00, 8'h7F, 6'h18, 1'b1, "R7 dec overflow");
    endtask

    task automatic t_shift();
        run(5'd13, 8'h81, 8'h00, 6'h20, 8'h02, 6'h39, 1'b1, "R8 shl");
        run(5'd14, 8'h01, 8'h00, 6'h00, 8'h00, 6'h1B, 1'b1, "R8 shr");
        run(5'd15, 8'h80, 8'h00, 6'h01, 8'h01, 6'h19, 1'b1, "R9 rol");
        run(5'd16, 8'h01, 8'h00, 6'h01, 8'h80, 6'h15, 1'b1, "R9 ror");
        run(5'd17, 8'h81, 8'h00, 6'h00, 8'hC0, 6'h15, 1'b1, "R9 asr");
    endtask

    task automatic t_swap_unused();
        run(5'd18, 8'h3C, 8'h00, 6'h2A, 8'hC3, 6'h2A, 1'b1, "R10 swap");
        run(5'd31, 8'h5A, 8'hFF, 6'h15, 8'h5A, 6'h15, 1'b0, "R12 unused 31");
        run(5'd19, 8'hA5, 8'h00, 6'h2A, 8'hA5, 6'h2A, 1'b0, "R12 unused 19");
    endtask

    initial begin
        op = '0; a = '0; b = '0; fl = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_com_neg();
        t_step();
        t_shift();
        t_swap_unused();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule